// File: doc/BRIEF.md
# Banked RAM Address Generator

This block turns the data-memory operand of a small 8-bit controller core into a physical RAM address. It owns the 8-bit pointer register. Its top bits pick one of eight RAM banks, and its full value serves as the address for indirect accesses. A direct operand at or above 10h lands in the 16-entry window of the currently selected bank. A direct operand below 10h always reaches the shared low registers. The reserved operand 00h means "indirect", and the pointer itself becomes the address.

Access requests enter on a valid/ready channel, and the resulting address leaves on a second valid/ready channel through a single register stage. A request is accepted when `req_vld` and `req_rdy` are both high at a clock edge. `req_rdy` is high whenever the output stage is empty or its contents are being taken in the same cycle. While `addr_vld` is high and `addr_rdy` is low, the output word is frozen and no new request is accepted.

The pointer-maintenance strobes (load, bank load, increment) are plain control pins. They act on the pointer independently of the request channel. The pointer and its increment-zero flag are visible as outputs, so the core can build skip-if-zero loops.

Top module: `ram_addr_gen`

## Requirements
- R1: After reset, `ptr_q` is 00h, `ptr_zero` is 0 and `addr_vld` is 0.
- R2: A direct operand from 01h to 0Fh produces the address 0 concatenated with the operand (01h to 0Fh), whatever the pointer holds.
- R3: A direct operand from 10h to 1Fh produces {`ptr_q[7:5]`, operand[4:0]}. For example, a pointer of 70h with operand 1Fh gives 7Fh.
- R4: Operand 00h selects indirect access, and the address equals the full 8-bit `ptr_q`.
- R5: An accepted request appears on `addr` with `addr_vld` high one cycle later. The address is formed from the pointer value held before any pointer update in the same cycle.
- R6: While `addr_vld` is 1 and `addr_rdy` is 0, `addr_vld` and `addr` stay unchanged and `req_rdy` is 0.
- R7: `ptr_wr` loads `ptr_wdata` into the pointer on the next edge. It has priority over `bank_ld` and `ptr_inc`.
- R8: `bank_ld` without `ptr_wr` sets `ptr_q[7:5]` to `bank_sel` and leaves `ptr_q[4:0]` unchanged. It has priority over `ptr_inc`.
- R9: `ptr_inc` alone adds one to the pointer modulo 256, so FFh wraps to 00h.
- R10: Each increment sets `ptr_zero` to 1 if its result is 00h and to 0 otherwise. `ptr_wr` and `bank_ld` leave `ptr_zero` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Access request valid |
| req_rdy | output | 1 | Access request can be accepted |
| req_opnd | input | 5 | Memory operand; 00h means indirect |
| ptr_wr | input | 1 | Load pointer from `ptr_wdata` |
| ptr_wdata | input | 8 | Pointer load value |
| bank_ld | input | 1 | Rewrite the pointer bank bits only |
| bank_sel | input | 3 | Bank number for `bank_ld` |
| ptr_inc | input | 1 | Increment the pointer |
| ptr_q | output | 8 | Current pointer value |
| ptr_zero | output | 1 | Last increment produced 00h |
| addr_vld | output | 1 | Physical address valid |
| addr_rdy | input | 1 | Consumer accepts the address |
| addr | output | 8 | Physical RAM address |

## Verification
The bench targets the operand boundaries 0Fh/10h and 1Fh, and the indirect code 00h. A design that banked low operands, or treated 00h as a direct register, would show wrong addresses there. It exercises the collisions of load with increment and of bank load with increment, and checks that a request issued in the same cycle as a pointer update uses the old pointer. A design with the wrong priority, or one that bypassed the new pointer into the address, would differ from the scoreboard. It also wraps the pointer from FFh to 00h and runs a full sweep in which bit 4 is forced before each access, so that a missing zero flag or a broken wrap would either never end the loop or leave a window out. Finally, it stalls the output while offering a new request, which catches an output stage that drops or overwrites a held address.

// File: rtl/rag_pkg.sv
package rag_pkg;
  typedef enum logic [1:0] {
    ACC_GLOBAL   = 2'd0,
    ACC_BANKED   = 2'd1,
    ACC_INDIRECT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/rag_ptr_reg.sv
module rag_ptr_reg #(
  parameter int BANK_W = 3,
  parameter int OFS_W  = 4,
  localparam int PW    = BANK_W + OFS_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [PW-1:0]     wdata,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              inc,
  output logic [PW-1:0]     ptr,
  output logic              zero
);
  localparam int LOW_W = PW - BANK_W;

  logic [PW-1:0] ptr_plus;
  assign ptr_plus = ptr + PW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr  <= '0;
      zero <= 1'b0;
    end else if (wr) begin
      ptr <= wdata;
    end else if (bank_ld) begin
      ptr <= {bank_sel, ptr[LOW_W-1:0]};
    end else if (inc) begin
      ptr  <= ptr_plus;
      zero <= (ptr_plus == '0);
    end
  end
endmodule

// File: rtl/rag_addr_map.sv
module rag_addr_map
  import rag_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int OFS_W     = 4,
  parameter int INDF_CODE = 0,
  localparam int OPND_W   = OFS_W + 1,
  localparam int AW       = BANK_W + OPND_W
) (
  input  logic [OPND_W-1:0] opnd,
  input  logic [AW-1:0]     ptr,
  output logic [AW-1:0]     paddr,
  output acc_kind_e         kind
);
  always_comb begin
    if (opnd == OPND_W'(INDF_CODE)) begin
      kind  = ACC_INDIRECT;
      paddr = ptr;
    end else if (opnd[OPND_W-1]) begin
      kind  = ACC_BANKED;
      paddr = {ptr[AW-1 -: BANK_W], opnd};
    end else begin
      kind  = ACC_GLOBAL;
      paddr = AW'(opnd);
    end
  end
endmodule

// File: rtl/rag_out_stage.sv
module rag_out_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  output logic         in_rdy,
  input  logic [W-1:0] in_data,
  output logic         out_vld,
  input  logic         out_rdy,
  output logic [W-1:0] out_data
);
  assign in_rdy = !out_vld || out_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_vld  <= 1'b0;
      out_data <= '0;
    end else if (in_rdy) begin
      out_vld <= in_vld;
      if (in_vld) out_data <= in_data;
    end
  end
endmodule

// File: rtl/ram_addr_gen.sv
module ram_addr_gen
  import rag_pkg::*;
#(
  parameter int BANK_W    = 3,
  parameter int OFS_W     = 4,
  parameter int INDF_CODE = 0,
  localparam int OPND_W   = OFS_W + 1,
  localparam int AW       = BANK_W + OPND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_vld,
  output logic              req_rdy,
  input  logic [OPND_W-1:0] req_opnd,
  input  logic              ptr_wr,
  input  logic [AW-1:0]     ptr_wdata,
  input  logic              bank_ld,
  input  logic [BANK_W-1:0] bank_sel,
  input  logic              ptr_inc,
  output logic [AW-1:0]     ptr_q,
  output logic              ptr_zero,
  output logic              addr_vld,
  input  logic              addr_rdy,
  output logic [AW-1:0]     addr
);
  logic [AW-1:0] mapped;
  acc_kind_e     kind;

  rag_ptr_reg #(.BANK_W(BANK_W), .OFS_W(OFS_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .wr(ptr_wr), .wdata(ptr_wdata),
    .bank_ld(bank_ld), .bank_sel(bank_sel), .inc(ptr_inc),
    .ptr(ptr_q), .zero(ptr_zero)
  );

  rag_addr_map #(.BANK_W(BANK_W), .OFS_W(OFS_W), .INDF_CODE(INDF_CODE)) u_map (
    .opnd(req_opnd), .ptr(ptr_q), .paddr(mapped), .kind(kind)
  );

  rag_out_stage #(.W(AW)) u_out (
    .clk(clk), .rst_n(rst_n), .in_vld(req_vld), .in_rdy(req_rdy),
    .in_data(mapped), .out_vld(addr_vld), .out_rdy(addr_rdy), .out_data(addr)
  );
endmodule

// File: rtl/ram_addr_gen_chk.sv
module ram_addr_gen_chk #(
  parameter int BANK_W    = 3,
  parameter int OFS_W     = 4,
  parameter int INDF_CODE = 0,
  localparam int OPND_W   = OFS_W + 1,
  localparam int AW       = BANK_W + OPND_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_vld,
  input logic              req_rdy,
  input logic [OPND_W-1:0] req_opnd,
  input logic              ptr_wr,
  input logic [AW-1:0]     ptr_wdata,
  input logic              bank_ld,
  input logic [BANK_W-1:0] bank_sel,
  input logic              ptr_inc,
  input logic [AW-1:0]     ptr_q,
  input logic              ptr_zero,
  input logic              addr_vld,
  input logic              addr_rdy,
  input logic [AW-1:0]     addr
);
  localparam int LOW_W = AW - BANK_W;

  // R5
  accept_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_rdy |=> addr_vld);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_vld && !addr_rdy |=> addr_vld && $stable(addr));

  // R4
  indirect_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld && req_rdy && req_opnd == OPND_W'(INDF_CODE) |=> addr == $past(ptr_q));

  // R7
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_wr |=> ptr_q == $past(ptr_wdata));

  // R8
  bank_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_ld && !ptr_wr |=> ptr_q[AW-1 -: BANK_W] == $past(bank_sel)
                        && ptr_q[LOW_W-1:0] == $past(ptr_q[LOW_W-1:0]));

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc && !ptr_wr && !bank_ld |=> ptr_q == AW'($past(ptr_q) + 1'b1));

  // R10
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_inc && !ptr_wr && !bank_ld |=> ptr_zero == (ptr_q == '0));

  // R10
  zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_wr || bank_ld) |=> $stable(ptr_zero));
endmodule

bind ram_addr_gen ram_addr_gen_chk #(
  .BANK_W(BANK_W), .OFS_W(OFS_W), .INDF_CODE(INDF_CODE)
) u_chk (.*);

// File: tb/ram_addr_gen_test.sv
`timescale 1ns/1ps
module ram_addr_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_vld = 1'b0;
  logic       req_rdy;
  logic [4:0] req_opnd = '0;
  logic       ptr_wr = 1'b0;
  logic [7:0] ptr_wdata = '0;
  logic       bank_ld = 1'b0;
  logic [2:0] bank_sel = '0;
  logic       ptr_inc = 1'b0;
  logic [7:0] ptr_q;
  logic       ptr_zero;
  logic       addr_vld;
  logic       addr_rdy = 1'b1;
  logic [7:0] addr;

  int checks = 0;
  int failures = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] m_ptr = 8'h00;
  logic       m_zero = 1'b0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  ram_addr_gen uut (
    .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_rdy(req_rdy),
    .req_opnd(req_opnd), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
    .bank_ld(bank_ld), .bank_sel(bank_sel), .ptr_inc(ptr_inc),
    .ptr_q(ptr_q), .ptr_zero(ptr_zero), .addr_vld(addr_vld),
    .addr_rdy(addr_rdy), .addr(addr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] map_addr(input logic [4:0] op, input logic [7:0] p);
    if (op == 5'h00) return p;
    if (op[4]) return {p[7:5], op};
    return {3'b000, op};
  endfunction

  // Scoreboard monitor: transfer happens at the next posedge.
  always @(negedge clk) begin
    if (rst_n && addr_vld && addr_rdy) begin
      if (exp_q.size() == 0) begin
        checks++; failures++;
        $display("FAIL R5 unexpected address actual=%0h expected=none", addr);
      end else begin
        chk(tag_q.pop_front(), addr, exp_q.pop_front());
      end
    end
  end

  // One cycle of stimulus; returns just after the sampling edge with inputs idle.
  task automatic step(input bit rv, input logic [4:0] op, input string tag,
                      input bit wr, input logic [7:0] wd,
                      input bit bl, input logic [2:0] bs, input bit inc);
    @(negedge clk);
    req_vld = rv; req_opnd = op; ptr_wr = wr; ptr_wdata = wd;
    bank_ld = bl; bank_sel = bs; ptr_inc = inc;
    if (rv && req_rdy) begin
      exp_q.push_back(map_addr(op, m_ptr));
      tag_q.push_back(tag);
    end
    if (wr) m_ptr = wd;
    else if (bl) m_ptr = {bs, m_ptr[4:0]};
    else if (inc) begin m_ptr = m_ptr + 8'd1; m_zero = (m_ptr == 8'h00); end
    @(posedge clk); #1;
    req_vld = 0; ptr_wr = 0; bank_ld = 0; ptr_inc = 0;
  endtask

  task automatic chk_ptr(input string req);
    @(negedge clk);
    chk(req, ptr_q, m_ptr);
    chk(req, ptr_zero, m_zero);
  endtask

  initial begin
    #(8 * 200000);
    checks++; failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 ptr", ptr_q, 8'h00);
    chk("R1 zero", ptr_zero, 1'b0);
    chk("R1 vld", addr_vld, 1'b0);
    @(posedge clk); #1;

    // R7 load, R3 banked, R2 global, R4 indirect
    step(0, 0, "", 1, 8'h70, 0, 0, 0);
    chk_ptr("R7 load");
    step(1, 5'h10, "R3 bank3 10h", 0, 0, 0, 0, 0);
    step(1, 5'h1F, "R3 bank3 1Fh", 0, 0, 0, 0, 0);
    step(1, 5'h0F, "R2 global 0Fh", 0, 0, 0, 0, 0);
    step(1, 5'h01, "R2 global 01h", 0, 0, 0, 0, 0);
    step(1, 5'h00, "R4 indirect", 0, 0, 0, 0, 0);

    // R8 bank load keeps low bits, then R9 increment
    step(0, 0, "", 0, 0, 1, 3'd6, 0);
    chk_ptr("R8 bank6");
    step(1, 5'h12, "R3 bank6 12h", 0, 0, 0, 0, 1);
    chk_ptr("R9 inc");

    // R9 wrap and R10 zero flag
    step(0, 0, "", 1, 8'hFF, 0, 0, 0);
    step(0, 0, "", 0, 0, 0, 0, 1);
    chk_ptr("R10 wrap zero");
    step(0, 0, "", 1, 8'h0A, 0, 0, 0);
    chk_ptr("R10 hold on load");
    step(0, 0, "", 0, 0, 0, 0, 1);
    chk_ptr("R10 clear");

    // R8 over R9, R7 over R9
    step(0, 0, "", 1, 8'h0A, 0, 0, 0);
    step(0, 0, "", 0, 0, 1, 3'd5, 1);
    chk_ptr("R8 priority");
    step(0, 0, "", 1, 8'h44, 0, 0, 1);
    chk_ptr("R7 priority");

    // R5 same-cycle update uses the old pointer
    step(1, 5'h00, "R5 old ptr indirect", 1, 8'h33, 0, 0, 0);
    step(1, 5'h18, "R5 old ptr banked", 0, 0, 1, 3'd7, 0);
    chk_ptr("R5 ptr after");

    // R6 back-pressure
    addr_rdy = 1'b0;
    step(1, 5'h15, "R6 stalled", 0, 0, 0, 0, 0);
    @(negedge clk);
    held = addr;
    chk("R6 vld", addr_vld, 1'b1);
    chk("R6 rdy low", req_rdy, 1'b0);
    @(posedge clk); #1;
    step(1, 5'h03, "R6 refused", 0, 0, 0, 0, 0);
    @(negedge clk);
    chk("R6 held", addr, held);
    chk("R6 vld held", addr_vld, 1'b1);
    @(posedge clk); #1;
    addr_rdy = 1'b1;
    @(posedge clk); #1;

    // Sweep of banked windows: force bit 4, indirect access, increment to zero
    step(0, 0, "", 1, 8'h00, 0, 0, 0);
    for (int i = 0; i < 300; i++) begin
      step(0, 0, "", 1, m_ptr | 8'h10, 0, 0, 0);
      step(1, 5'h00, "R4 sweep", 0, 0, 0, 0, 1);
      @(negedge clk);
      if (ptr_zero) break;
      @(posedge clk); #1;
    end
    chk_ptr("R9 sweep end");

    repeat (4) @(posedge clk);
    chk("R5 drained", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule